// File: doc/BRIEF.md
# Three-Level Nested Interrupt Arbiter

This block sits beside a CPU core and decides which pending interrupt request the core should service, and at which instruction boundary. Each source has a request flag, an individual enable and a one-bit priority selector. A global enable gates every source except source 0, the power-fail source. Source 0 is controlled only by its own enable and always sits alone on a third, top level above the high and low levels.

The arbiter evaluates requests only when the core signals that an instruction has completed. It picks the highest level first and then the lowest source index within that level. The winning source is presented with its fixed vector address and held until the core acknowledges it. Three in-service bits, one per level, record nesting. A new request is raised only when its level is strictly above the highest level currently in service. A return-from-interrupt pulse clears the highest in-service bit. After a return-from-interrupt, or after a write to an enable or priority register, one more instruction must complete before any request is raised.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `svc_req` is 0 and `in_service` is 3'b000.
- R2: When `glb_en` is 0, sources 1 to NSRC-1 are never requested. Source 0 is still requested when `req_flags[0]` and `src_en[0]` are both 1.
- R3: A source whose `src_en` bit is 0 is never requested, even with `glb_en` at 1.
- R4: Level wins over natural priority. A source with `prio_hi`=1 beats any source with `prio_hi`=0, whatever their indices.
- R5: Among pending sources on the same level, the lowest index wins.
- R6: `svc_req` rises only in the cycle after a cycle with `insn_done` high. With no `insn_done`, pending sources raise nothing.
- R7: An `insn_done` cycle with `insn_was_reti` or `insn_wrote_cfg` high raises no request. A later plain `insn_done` may raise one.
- R8: While `svc_req` is 1 and `ack` is 0, `svc_req`, `svc_idx`, `svc_vec` and `svc_level` hold their values, even if other sources become pending.
- R9: `ack` while `svc_req` is 1 drops `svc_req` in the next cycle and sets in-service bit `svc_level`. Bit 0 is low, bit 1 is high, bit 2 is top.
- R10: A request is raised only if its level is strictly above the highest set in-service bit. Same-level and lower-level sources wait, and are raised later once the level is released.
- R11: A `reti_pulse` clears the highest set in-service bit only.
- R12: `svc_vec` equals VEC_BASE + `svc_idx` * VEC_STRIDE. The defaults are 16'h0003 and 8.
- R13: Source 0 is always granted with `svc_level` = 2 (top), whatever `prio_hi[0]` says. Sources 1 and up get level 1 when their `prio_hi` bit is 1 and level 0 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_flags | input | NSRC | Pending request flag per source; bit 0 is power-fail |
| src_en | input | NSRC | Per-source enable; bit 0 enables power-fail |
| glb_en | input | 1 | Global enable for sources 1 and up |
| prio_hi | input | NSRC | 1 = high level, 0 = low level; bit 0 unused |
| insn_done | input | 1 | Instruction-boundary strobe |
| insn_was_reti | input | 1 | Finishing instruction was a return-from-interrupt |
| insn_wrote_cfg | input | 1 | Finishing instruction wrote an enable or priority register |
| reti_pulse | input | 1 | Return-from-interrupt executed; leave current level |
| ack | input | 1 | Core accepts the presented request |
| svc_req | output | 1 | Service request pending |
| svc_idx | output | IDXW | Index of requested source |
| svc_vec | output | AW | Vector address of requested source |
| svc_level | output | 2 | Level of requested source (0 low, 1 high, 2 top) |
| in_service | output | 3 | In-service bit per level |

## Verification
The assertions assume that the core never raises `ack` unless `svc_req` is high. They also assume it never raises `ack` and `reti_pulse` in the same cycle, and never raises `reti_pulse` with no level in service. The bench drives every strobe for exactly one cycle, on the falling edge, through dedicated tasks. It acknowledges only after it has checked that a request is presented, and it issues one return-from-interrupt for each acknowledged request. Request flags are cleared by the bench before the matching return, which matches how a service routine would clear its source.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_HIGH = 2'd1,
        LVL_TOP  = 2'd2
    } lvl_e;

    localparam int NUM_LVL = 3;

    // rank 0 means nothing in service; rank n means level n-1
    function automatic logic [1:0] svc_rank(input logic [NUM_LVL-1:0] bits);
        if (bits[2])      return 2'd3;
        else if (bits[1]) return 2'd2;
        else if (bits[0]) return 2'd1;
        else              return 2'd0;
    endfunction

endpackage

// File: rtl/irq_level_mask.sv
module irq_level_mask #(
    parameter int NSRC = 8
) (
    input  logic [NSRC-1:0] req_flags,
    input  logic [NSRC-1:0] src_en,
    input  logic            glb_en,
    input  logic [NSRC-1:0] prio_hi,
    output logic [NSRC-1:0] top_v,
    output logic [NSRC-1:0] high_v,
    output logic [NSRC-1:0] low_v
);
    localparam logic [NSRC-1:0] PF_BIT = NSRC'(1);

    logic [NSRC-1:0] gated;

    always_comb begin
        gated  = req_flags & src_en & {NSRC{glb_en}} & ~PF_BIT;
        top_v  = req_flags & src_en & PF_BIT;
        high_v = gated & prio_hi;
        low_v  = gated & ~prio_hi;
    end
endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack
    import irq_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  lvl_e               push_lvl,
    input  logic               pop,
    output logic [NUM_LVL-1:0] in_service,
    output logic [1:0]         cur_rank
);
    typedef struct packed {
        logic [NUM_LVL-1:0] bits;
    } stk_t;

    stk_t stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        if (pop) begin
            if (stk_q.bits[2])      stk_d.bits[2] = 1'b0;
            else if (stk_q.bits[1]) stk_d.bits[1] = 1'b0;
            else                    stk_d.bits[0] = 1'b0;
        end
        if (push) begin
            case (push_lvl)
                LVL_TOP:  stk_d.bits[2] = 1'b1;
                LVL_HIGH: stk_d.bits[1] = 1'b1;
                default:  stk_d.bits[0] = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    assign in_service = stk_q.bits;
    assign cur_rank   = svc_rank(stk_q.bits);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int          NSRC       = 8,
    parameter int          AW         = 16,
    parameter logic [15:0] VEC_BASE   = 16'h0003,
    parameter int          VEC_STRIDE = 8,
    localparam int         IDXW       = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_flags,
    input  logic [NSRC-1:0] src_en,
    input  logic            glb_en,
    input  logic [NSRC-1:0] prio_hi,
    input  logic            insn_done,
    input  logic            insn_was_reti,
    input  logic            insn_wrote_cfg,
    input  logic            reti_pulse,
    input  logic            ack,
    output logic            svc_req,
    output logic [IDXW-1:0] svc_idx,
    output logic [AW-1:0]   svc_vec,
    output logic [1:0]      svc_level,
    output logic [2:0]      in_service
);
    typedef struct packed {
        logic            pend;
        logic [IDXW-1:0] idx;
        lvl_e            lvl;
    } req_t;

    req_t st_d, st_q;

    logic [NSRC-1:0] lvl_vec   [NUM_LVL];
    logic            lvl_found [NUM_LVL];
    logic [IDXW-1:0] lvl_idx   [NUM_LVL];

    logic            win_found;
    logic [IDXW-1:0] win_idx;
    lvl_e            win_lvl;
    logic [1:0]      win_rank;
    logic [1:0]      cur_rank;
    logic            boundary_ok;
    logic            push;

    irq_level_mask #(.NSRC(NSRC)) u_mask (
        .req_flags (req_flags),
        .src_en    (src_en),
        .glb_en    (glb_en),
        .prio_hi   (prio_hi),
        .top_v     (lvl_vec[2]),
        .high_v    (lvl_vec[1]),
        .low_v     (lvl_vec[0])
    );

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_pick
        irq_first_set #(.N(NSRC), .IW(IDXW)) u_pick (
            .vec   (lvl_vec[g]),
            .found (lvl_found[g]),
            .idx   (lvl_idx[g])
        );
    end

    // level outranks natural order: scan from top level downward
    always_comb begin
        win_found = 1'b0;
        win_idx   = '0;
        win_lvl   = LVL_LOW;
        win_rank  = 2'd0;
        for (int g = NUM_LVL - 1; g >= 0; g--) begin
            if (!win_found && lvl_found[g]) begin
                win_found = 1'b1;
                win_idx   = lvl_idx[g];
                win_lvl   = lvl_e'(g);
                win_rank  = 2'(g + 1);
            end
        end
    end

    assign boundary_ok = insn_done && !insn_was_reti && !insn_wrote_cfg;
    assign push        = st_q.pend && ack;

    always_comb begin
        st_d = st_q;
        if (push) st_d.pend = 1'b0;
        if (!st_q.pend && boundary_ok && win_found && (win_rank > cur_rank)) begin
            st_d.pend = 1'b1;
            st_d.idx  = win_idx;
            st_d.lvl  = win_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{pend: 1'b0, idx: '0, lvl: LVL_LOW};
        else        st_q <= st_d;
    end

    irq_svc_stack u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_lvl   (st_q.lvl),
        .pop        (reti_pulse),
        .in_service (in_service),
        .cur_rank   (cur_rank)
    );

    assign svc_req   = st_q.pend;
    assign svc_idx   = st_q.idx;
    assign svc_level = st_q.lvl;
    assign svc_vec   = AW'(VEC_BASE) + AW'(st_q.idx) * AW'(VEC_STRIDE);
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
    parameter int NSRC = 8,
    parameter int IDXW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            glb_en,
    input logic            insn_done,
    input logic            insn_was_reti,
    input logic            insn_wrote_cfg,
    input logic            reti_pulse,
    input logic            ack,
    input logic            svc_req,
    input logic [IDXW-1:0] svc_idx,
    input logic [1:0]      svc_level,
    input logic [2:0]      in_service
);
    function automatic logic [1:0] rank_of(input logic [2:0] b);
        if (b[2])      return 2'd3;
        else if (b[1]) return 2'd2;
        else if (b[0]) return 2'd1;
        else           return 2'd0;
    endfunction

    a_r6_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(svc_req) |-> $past(insn_done));

    a_r7_deferral: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(svc_req) |-> (!$past(insn_was_reti) && !$past(insn_wrote_cfg)));

    a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && !ack) |=> (svc_req && $stable(svc_idx) && $stable(svc_level)));

    a_r9_ack_marks_level: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && ack && !reti_pulse) |=>
            (!svc_req && (((in_service >> $past(svc_level)) & 3'b001) != 3'b000)));

    a_r10_strictly_above: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(svc_req) |-> (2'(svc_level + 2'd1) > rank_of($past(in_service))));

    a_r13_powerfail_top: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && svc_idx == '0) |-> (svc_level == 2'd2));

    a_r2_masked_level: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(svc_req) && !$past(glb_en)) |-> (svc_idx == '0));
endmodule

bind irq_arbiter irq_arbiter_chk #(.NSRC(NSRC), .IDXW(IDXW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .glb_en         (glb_en),
    .insn_done      (insn_done),
    .insn_was_reti  (insn_was_reti),
    .insn_wrote_cfg (insn_wrote_cfg),
    .reti_pulse     (reti_pulse),
    .ack            (ack),
    .svc_req        (svc_req),
    .svc_idx        (svc_idx),
    .svc_level      (svc_level),
    .in_service     (in_service)
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
    localparam int NSRC = 8;
    localparam int IDXW = 3;
    localparam int AW   = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NSRC-1:0] req_flags, src_en, prio_hi;
    logic            glb_en, insn_done, insn_was_reti, insn_wrote_cfg, reti_pulse, ack;
    logic            svc_req;
    logic [IDXW-1:0] svc_idx;
    logic [AW-1:0]   svc_vec;
    logic [1:0]      svc_level;
    logic [2:0]      in_service;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    irq_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req_flags(req_flags), .src_en(src_en),
        .glb_en(glb_en), .prio_hi(prio_hi), .insn_done(insn_done),
        .insn_was_reti(insn_was_reti), .insn_wrote_cfg(insn_wrote_cfg),
        .reti_pulse(reti_pulse), .ack(ack), .svc_req(svc_req), .svc_idx(svc_idx),
        .svc_vec(svc_vec), .svc_level(svc_level), .in_service(in_service)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic boundary(input logic was_reti, input logic wrote_cfg);
        @(negedge clk);
        insn_done = 1'b1; insn_was_reti = was_reti; insn_wrote_cfg = wrote_cfg;
        @(negedge clk);
        insn_done = 1'b0; insn_was_reti = 1'b0; insn_wrote_cfg = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic do_reti();
        @(negedge clk); reti_pulse = 1'b1;
        @(negedge clk); reti_pulse = 1'b0;
    endtask

    function automatic int exp_vec(input int idx);
        return 3 + idx * 8;
    endfunction

    task automatic expect_grant(input string tag, input int idx, input int lvl);
        chk({tag, " req"}, int'(svc_req), 1);
        chk({tag, " idx"}, int'(svc_idx), idx);
        chk({tag, " level"}, int'(svc_level), lvl);
        chk({"R12 ", tag, " vec"}, int'(svc_vec), exp_vec(idx));
    endtask

    task automatic t_reset();
        chk("R1 svc_req after reset", int'(svc_req), 0);
        chk("R1 in_service after reset", int'(in_service), 0);
    endtask

    task automatic t_global_mask();
        src_en = '1; prio_hi = '0; glb_en = 1'b0;
        req_flags = 8'b0000_1000;
        boundary(1'b0, 1'b0);
        chk("R2 global disable masks source 3", int'(svc_req), 0);
        req_flags = 8'b0000_1001;
        boundary(1'b0, 1'b0);
        expect_grant("R2 R13 power-fail ignores global enable", 0, 2);
        do_ack();
        chk("R9 ack drops request", int'(svc_req), 0);
        chk("R9 top level in service", int'(in_service), 3'b100);
        req_flags = '0;
        do_reti();
        chk("R11 reti clears top", int'(in_service), 0);
        glb_en = 1'b1;
    endtask

    task automatic t_src_enable();
        src_en = 8'b1110_1111; req_flags = 8'b0001_0000;
        boundary(1'b0, 1'b0);
        chk("R3 disabled source 4 not requested", int'(svc_req), 0);
        src_en = '1; req_flags = '0;
    endtask

    task automatic t_no_boundary();
        req_flags = 8'b0010_0000;
        repeat (4) @(negedge clk);
        chk("R6 no request without insn_done", int'(svc_req), 0);
        boundary(1'b0, 1'b0);
        expect_grant("R6 request after boundary", 5, 0);
        do_ack();
        req_flags = '0;
        do_reti();
    endtask

    task automatic t_level_vs_natural();
        prio_hi = 8'b0010_0000; req_flags = 8'b0010_0100;
        boundary(1'b0, 1'b0);
        expect_grant("R4 high level beats lower index", 5, 1);
        do_ack();
        chk("R9 high level in service", int'(in_service), 3'b010);
        boundary(1'b0, 1'b0);
        chk("R10 low source waits under high", int'(svc_req), 0);
        req_flags = 8'b0000_0100;
        do_reti();
        chk("R11 reti clears high", int'(in_service), 0);
        boundary(1'b0, 1'b0);
        expect_grant("R10 waiting low source granted later", 2, 0);
        do_ack();
        req_flags = '0;
        do_reti();
        prio_hi = '0;
    endtask

    task automatic t_tie_and_hold();
        prio_hi = 8'b0100_1010; req_flags = 8'b0100_1000;
        boundary(1'b0, 1'b0);
        expect_grant("R5 lowest index wins on same level", 3, 1);
        req_flags = 8'b0100_1010;
        boundary(1'b0, 1'b0);
        boundary(1'b0, 1'b0);
        chk("R8 held index unchanged", int'(svc_idx), 3);
        chk("R8 held request still up", int'(svc_req), 1);
        do_ack();
        req_flags = '0;
        do_reti();
        prio_hi = '0;
    endtask

    task automatic t_preempt();
        prio_hi = 8'b0000_0100;
        req_flags = 8'b0100_0000;
        boundary(1'b0, 1'b0);
        expect_grant("R13 low source level", 6, 0);
        do_ack();
        req_flags = 8'b1000_0000;
        boundary(1'b0, 1'b0);
        chk("R10 same level does not preempt", int'(svc_req), 0);
        req_flags = 8'b1000_0100;
        boundary(1'b0, 1'b0);
        expect_grant("R10 high preempts low", 2, 1);
        do_ack();
        chk("R9 nested low+high", int'(in_service), 3'b011);
        prio_hi = 8'b0000_0101;
        req_flags = 8'b1000_0101;
        boundary(1'b0, 1'b0);
        expect_grant("R13 power-fail preempts high", 0, 2);
        do_ack();
        chk("R9 all three levels", int'(in_service), 3'b111);
        req_flags = 8'b1000_0000;
        do_reti();
        chk("R11 first reti leaves low+high", int'(in_service), 3'b011);
        do_reti();
        chk("R11 second reti leaves low", int'(in_service), 3'b001);
        req_flags = '0;
        do_reti();
        chk("R11 third reti empties", int'(in_service), 0);
        prio_hi = '0;
    endtask

    task automatic t_deferral();
        prio_hi = 8'b0001_0000; req_flags = 8'b0001_0000;
        boundary(1'b1, 1'b0);
        chk("R7 no grant right after reti", int'(svc_req), 0);
        boundary(1'b0, 1'b1);
        chk("R7 no grant right after config write", int'(svc_req), 0);
        boundary(1'b0, 1'b0);
        expect_grant("R7 grant after extra instruction", 4, 1);
        do_ack();
        req_flags = '0;
        do_reti();
    endtask

    initial begin
        rst_n = 1'b0; req_flags = '0; src_en = '0; prio_hi = '0; glb_en = 1'b0;
        insn_done = 1'b0; insn_was_reti = 1'b0; insn_wrote_cfg = 1'b0;
        reti_pulse = 1'b0; ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_global_mask();
        t_src_enable();
        t_no_boundary();
        t_level_vs_natural();
        t_tie_and_hold();
        t_preempt();
        t_deferral();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule